// File: doc/BRIEF.md
# Priority-Level Interrupt Controller

This block collects eleven interrupt request lines from the peripherals around a small 8-bit core and decides which of them start an interrupt entry. A rising edge on a line records a pending flag and, for maskable sources, sets a bit in one of two request registers. A falling edge clears both. Software reaches the two enable registers and the two request registers through a simple byte bus.

Each cycle, while no entry is outstanding, the controller takes the lowest-numbered pending flag and clears it. If the source is allowed, it raises an entry request with that source's vector address. A maskable source is allowed only when its enable bit and the core's global enable are both set and, for most sources, when the core's current 3-bit priority level is below a threshold set per source. Three sources ignore all masking. A pending flag that is masked is still dropped after its turn in the scan, but its request bit stays visible so software can poll it. Every pending flag, masked or not, drives a wake output for a halted core.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset both enable registers and both request registers read 0x00, `entry_req_o` is low and `wake_o` is low.
- R2: Bus address 0x10 is enable byte 0, 0x11 enable byte 1, 0x12 request byte 0 and 0x13 request byte 1. A write with `bus_we_i` high stores the byte at the clock edge. `bus_rdata_o` shows the addressed register combinationally. Any other address reads 0x00, and a write to it changes nothing.
- R3: A rising edge on `irq_i[k]` sets pending flag k and that source's request bit. A falling edge clears both. A flag cleared this way never produces an entry.
- R4: The source indices, request bits and vectors are: 0 watchdog, vector 0x101C. 1 illegal opcode, vector 0x101E. 2 NMI, vector 0x101E. 3 DMA, request byte 0 bit 7, vector 0x1000. 4 timer 0, byte 0 bit 6, vector 0x1002. 5 external, byte 0 bit 4, vector 0x1006. 6 UART, byte 0 bit 3, vector 0x1008. 7 LCD, byte 0 bit 0, vector 0x100E. 8 timer 1, byte 1 bit 6, vector 0x1012. 9 clock, byte 1 bit 4, vector 0x1016. 10 parallel I/O, byte 1 bit 2, vector 0x101A.
- R5: Sources 0, 1 and 2 start an entry whatever the global enable, the enable registers and `level_i` hold.
- R6: A maskable source starts an entry only if `gie_i` is high and the enable bit in the same byte and position as its request bit is set.
- R7: A maskable source with a threshold also needs `level_i` below it: 7 for external, 6 for UART, 5 for LCD, 4 for timer 1, 3 for clock and 2 for parallel I/O. DMA and timer 0 have no threshold.
- R8: The scan serves the lowest pending index first and one index per cycle. It clears the served flag whether or not an entry follows. A masked source keeps its request bit set while its line stays high.
- R9: Only one entry is outstanding at a time. `entry_req_o` stays high with a stable `entry_vec_o` until `entry_done_i` is sampled high, and no flag is served meanwhile.
- R10: `wake_o` is high whenever any pending flag is set, including masked ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 11 | Interrupt request lines, one per source index |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| gie_i | input | 1 | Global interrupt enable from the core flags |
| level_i | input | 3 | Current priority level of the core |
| entry_done_i | input | 1 | Entry sequencer finished the outstanding entry |
| entry_req_o | output | 1 | Entry request |
| entry_vec_o | output | 16 | Vector address for the outstanding entry |
| wake_o | output | 1 | Wake a halted core |

## Verification
The bench builds the block with its default parameters: eleven sources, an 8-bit bus address with the registers at 0x10 to 0x13, and vectors based at 0x1000. With these values every source index, every threshold edge (level equal to and one below each tested limit), and the ordering between nonmaskable and maskable sources raised together can be reached. An entry is held open on purpose while other lines rise and fall, so the stall of the scan and the clearing of pending flags by a falling edge can both be observed at the ports.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;

  localparam int NSRC  = 11;
  localparam int LVL_W = 3;
  localparam int THR_W = LVL_W + 1;

  typedef struct packed {
    logic             maskable;  // has a request bit and enable bit
    logic             byte_sel;
    logic [2:0]       bit_pos;
    logic [THR_W-1:0] thr;       // level must be below; 8 = no limit
    logic [4:0]       voff;
  } src_info_t;

  function automatic src_info_t src_info(input int idx);
    src_info_t s;
    s = '{maskable: 1'b0, byte_sel: 1'b0, bit_pos: 3'd0, thr: 4'd8, voff: 5'h00};
    case (idx)
      0:  s.voff = 5'h1C;
      1:  s.voff = 5'h1E;
      2:  s.voff = 5'h1E;
      3:  s = '{1'b1, 1'b0, 3'd7, 4'd8, 5'h00};
      4:  s = '{1'b1, 1'b0, 3'd6, 4'd8, 5'h02};
      5:  s = '{1'b1, 1'b0, 3'd4, 4'd7, 5'h06};
      6:  s = '{1'b1, 1'b0, 3'd3, 4'd6, 5'h08};
      7:  s = '{1'b1, 1'b0, 3'd0, 4'd5, 5'h0E};
      8:  s = '{1'b1, 1'b1, 3'd6, 4'd4, 5'h12};
      9:  s = '{1'b1, 1'b1, 3'd4, 4'd3, 5'h16};
      10: s = '{1'b1, 1'b1, 3'd2, 4'd2, 5'h1A};
      default: s.voff = 5'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/irq_lvl_pend.sv
module irq_lvl_pend #(
  parameter int N = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] svc_clr_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] irq_q, pend_q;

  assign rise_o = irq_i & ~irq_q;
  assign fall_o = ~irq_i & irq_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_i;
      pend_q <= rise_o | (pend_q & ~fall_o & ~svc_clr_i);
    end
  end
endmodule

// File: rtl/irq_lvl_regs.sv
module irq_lvl_regs
  import irq_lvl_pkg::*;
#(
  parameter int          N       = NSRC,
  parameter int          AW      = 8,
  parameter logic [AW-1:0] EN_ADDR = 8'h10,
  parameter logic [AW-1:0] RQ_ADDR = 8'h12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [7:0]    bus_wdata_i,
  input  logic          bus_we_i,
  output logic [7:0]    bus_rdata_o,
  input  logic [N-1:0]  rise_i,
  input  logic [N-1:0]  fall_i,
  input  logic [N-1:0]  svc_i,
  output logic [15:0]   en_o
);
  localparam int NBYTE = 2;

  logic [NBYTE-1:0][7:0] en_q, rq_q;
  logic [15:0] set_m, clr_m;

  // hardware set/clear masks for the request bytes; a falling line beats a re-set
  always_comb begin
    src_info_t s;
    set_m = '0;
    clr_m = '0;
    for (int i = 0; i < N; i++) begin
      s = src_info(i);
      if (s.maskable) begin
        set_m[{s.byte_sel, s.bit_pos}] = rise_i[i] | (svc_i[i] & ~fall_i[i]);
        clr_m[{s.byte_sel, s.bit_pos}] = fall_i[i];
      end
    end
  end

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    logic       en_hit, rq_hit;
    logic [7:0] rq_wr;
    assign en_hit = bus_we_i && (bus_addr_i == EN_ADDR + AW'(b));
    assign rq_hit = bus_we_i && (bus_addr_i == RQ_ADDR + AW'(b));
    assign rq_wr  = rq_hit ? bus_wdata_i : rq_q[b];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[b] <= '0;
        rq_q[b] <= '0;
      end else begin
        if (en_hit) en_q[b] <= bus_wdata_i;
        rq_q[b] <= (rq_wr & ~clr_m[b*8 +: 8]) | set_m[b*8 +: 8];
      end
    end
  end

  assign en_o = en_q;

  always_comb begin
    bus_rdata_o = '0;
    for (int b = 0; b < NBYTE; b++) begin
      if (bus_addr_i == EN_ADDR + AW'(b)) bus_rdata_o = en_q[b];
      if (bus_addr_i == RQ_ADDR + AW'(b)) bus_rdata_o = rq_q[b];
    end
  end
endmodule

// File: rtl/irq_lvl_arb.sv
module irq_lvl_arb
  import irq_lvl_pkg::*;
#(
  parameter int          N        = NSRC,
  parameter logic [15:0] VEC_BASE = 16'h1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     pend_i,
  input  logic [15:0]      en_i,
  input  logic             gie_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             done_i,
  output logic [N-1:0]     svc_o,
  output logic             req_o,
  output logic [15:0]      vec_o
);
  localparam int IDX_W = $clog2(N);

  logic             sel_v, take, busy_q;
  logic [IDX_W-1:0] sel_idx;
  logic [15:0]      vec_q;
  src_info_t        sel_info;

  // lowest pending index wins
  always_comb begin
    sel_v   = 1'b0;
    sel_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        sel_v   = 1'b1;
        sel_idx = IDX_W'(i);
      end
    end
  end

  assign sel_info = src_info(int'(sel_idx));

  always_comb begin
    take = 1'b1;
    if (sel_info.maskable)
      take = en_i[{sel_info.byte_sel, sel_info.bit_pos}] && gie_i &&
             ({1'b0, level_i} < sel_info.thr);
  end

  always_comb begin
    svc_o = '0;
    if (sel_v && !busy_q) svc_o[sel_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      vec_q  <= '0;
    end else if (busy_q) begin
      if (done_i) busy_q <= 1'b0;
    end else if (sel_v && take) begin
      busy_q <= 1'b1;
      vec_q  <= VEC_BASE | {11'd0, sel_info.voff};
    end
  end

  assign req_o = busy_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int            AW       = 8,
  parameter logic [AW-1:0] EN_ADDR  = 8'h10,
  parameter logic [AW-1:0] RQ_ADDR  = 8'h12,
  parameter logic [15:0]   VEC_BASE = 16'h1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  irq_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [7:0]       bus_wdata_i,
  input  logic             bus_we_i,
  output logic [7:0]       bus_rdata_o,
  input  logic             gie_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             entry_done_i,
  output logic             entry_req_o,
  output logic [15:0]      entry_vec_o,
  output logic             wake_o
);
  logic [NSRC-1:0] rise, fall, pend, svc_oh;
  logic [15:0]     en;

  irq_lvl_pend #(.N(NSRC)) u_pend (
    .clk_i, .rst_ni, .irq_i,
    .svc_clr_i(svc_oh), .rise_o(rise), .fall_o(fall), .pend_o(pend)
  );

  irq_lvl_regs #(.N(NSRC), .AW(AW), .EN_ADDR(EN_ADDR), .RQ_ADDR(RQ_ADDR)) u_regs (
    .clk_i, .rst_ni, .bus_addr_i, .bus_wdata_i, .bus_we_i, .bus_rdata_o,
    .rise_i(rise), .fall_i(fall), .svc_i(svc_oh), .en_o(en)
  );

  irq_lvl_arb #(.N(NSRC), .VEC_BASE(VEC_BASE)) u_arb (
    .clk_i, .rst_ni, .pend_i(pend), .en_i(en), .gie_i, .level_i,
    .done_i(entry_done_i), .svc_o(svc_oh), .req_o(entry_req_o), .vec_o(entry_vec_o)
  );

  assign wake_o = |pend;
endmodule

// File: rtl/irq_lvl_chk.sv
module irq_lvl_chk
  import irq_lvl_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gie_i,
  input logic [LVL_W-1:0] level_i,
  input logic             entry_done_i,
  input logic             entry_req_o,
  input logic [15:0]      entry_vec_o,
  input logic             wake_o,
  input logic [NSRC-1:0]  rise,
  input logic [NSRC-1:0]  svc_oh
);
  a_r3_rise_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> wake_o);

  a_r4_vec_in_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_req_o |-> (entry_vec_o[15:5] == 11'h080 && !entry_vec_o[0]));

  a_r6_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(entry_req_o) && entry_vec_o < 16'h101C) |-> $past(gie_i));

  a_r7_pio_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(entry_req_o) && entry_vec_o == 16'h101A) |-> ($past(level_i) < 3'd2));

  a_r8_one_served: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(svc_oh));

  a_r9_hold_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_req_o && !entry_done_i) |=> (entry_req_o && $stable(entry_vec_o)));

  a_r9_no_scan_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_req_o |-> (svc_oh == '0));
endmodule

bind irq_level_ctrl irq_lvl_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .gie_i(gie_i), .level_i(level_i),
  .entry_done_i(entry_done_i), .entry_req_o(entry_req_o),
  .entry_vec_o(entry_vec_o), .wake_o(wake_o), .rise(rise), .svc_oh(svc_oh)
);

// File: tb/irq_level_ctrl_tb_top.sv
module irq_level_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] irq = '0;
  logic [7:0]  addr = '0, wdata = '0, rdata;
  logic        we = 1'b0, gie = 1'b0, done = 1'b0;
  logic [2:0]  level = '0;
  logic        req, wake;
  logic [15:0] vec;
  int          n_chk = 0, n_err = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_level_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_we_i(we), .bus_rdata_o(rdata), .gie_i(gie),
    .level_i(level), .entry_done_i(done), .entry_req_o(req),
    .entry_vec_o(vec), .wake_o(wake)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic raise(input logic [10:0] m);
    @(negedge clk);
    irq = irq | m;
  endtask

  task automatic clear_all();
    @(negedge clk);
    irq = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_entry(input logic [15:0] exp, input string tag, input bit ack);
    for (int k = 0; k < 8 && !req; k++) @(negedge clk);
    chk(req == 1'b1, {tag, " entry raised"}, req, 1);
    chk(vec == exp, {tag, " vector"}, vec, exp);
    if (ack) begin
      @(negedge clk);
      chk(req && vec == exp, {tag, " held R9"}, vec, exp);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      chk(req == 1'b0, {tag, " released R9"}, req, 0);
    end
  endtask

  task automatic expect_none(input int n, input string tag);
    bit seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (req) seen = 1'b1;
    end
    chk(!seen, {tag, " no entry"}, seen, 0);
  endtask

  task automatic t_reset();
    rd_chk(8'h10, 8'h00, "R1 en0");
    rd_chk(8'h11, 8'h00, "R1 en1");
    rd_chk(8'h12, 8'h00, "R1 rq0");
    rd_chk(8'h13, 8'h00, "R1 rq1");
    chk(req == 1'b0, "R1 entry_req", req, 0);
    chk(wake == 1'b0, "R1 wake", wake, 0);
  endtask

  task automatic t_bus();
    bus_wr(8'h10, 8'hA5);
    bus_wr(8'h11, 8'h3C);
    bus_wr(8'h12, 8'h5A);
    bus_wr(8'h13, 8'hC3);
    rd_chk(8'h10, 8'hA5, "R2 en0 readback");
    rd_chk(8'h11, 8'h3C, "R2 en1 readback");
    rd_chk(8'h12, 8'h5A, "R2 rq0 readback");
    rd_chk(8'h13, 8'hC3, "R2 rq1 readback");
    bus_wr(8'h20, 8'hFF);
    rd_chk(8'h20, 8'h00, "R2 unmapped read");
    rd_chk(8'h10, 8'hA5, "R2 unmapped write ignored");
    bus_wr(8'h12, 8'h00);
    bus_wr(8'h13, 8'h00);
    bus_wr(8'h10, 8'h00);
    bus_wr(8'h11, 8'h00);
  endtask

  // R5: nonmaskable sources with everything masked
  task automatic t_nonmask();
    gie = 1'b0; level = 3'd7;
    raise(11'b100); wait_entry(16'h101E, "R5 nmi", 1'b1); clear_all();
    raise(11'b001); wait_entry(16'h101C, "R5 watchdog", 1'b1); clear_all();
    raise(11'b010); wait_entry(16'h101E, "R5 illegal", 1'b1); clear_all();
  endtask

  // R6/R8/R10: masked source keeps request bit, drops pending
  task automatic t_masked();
    gie = 1'b1; level = 3'd0;
    raise(11'd1 << 5);
    @(negedge clk);
    chk(wake == 1'b1, "R10 wake on masked", wake, 1);
    rd_chk(8'h12, 8'h10, "R3 ext request bit");
    @(negedge clk);
    chk(wake == 1'b0, "R8 masked flag dropped", wake, 0);
    expect_none(5, "R6 enable clear");
    rd_chk(8'h12, 8'h10, "R8 masked bit stays");
    @(negedge clk);
    irq[5] = 1'b0;
    @(negedge clk);
    rd_chk(8'h12, 8'h00, "R3 fall clears bit");
    clear_all();
  endtask

  task automatic t_enable();
    level = 3'd0;
    bus_wr(8'h10, 8'hFF); bus_wr(8'h11, 8'hFF);
    gie = 1'b0;
    raise(11'd1 << 4); expect_none(5, "R6 gie low"); clear_all();
    gie = 1'b1;
    bus_wr(8'h10, 8'hBF);
    raise(11'd1 << 4); expect_none(5, "R6 tim0 enable off"); clear_all();
    bus_wr(8'h10, 8'h40);
    raise(11'd1 << 4); wait_entry(16'h1002, "R6 tim0", 1'b1); clear_all();
    bus_wr(8'h10, 8'h01);
    raise(11'd1 << 7); wait_entry(16'h100E, "R4 lcd", 1'b1); clear_all();
    bus_wr(8'h10, 8'h08);
    raise(11'd1 << 6); wait_entry(16'h1008, "R4 uart", 1'b1); clear_all();
    bus_wr(8'h11, 8'h10);
    raise(11'd1 << 9); wait_entry(16'h1016, "R4 clock", 1'b1); clear_all();
    bus_wr(8'h11, 8'hFF); bus_wr(8'h10, 8'hFF);
  endtask

  task automatic t_level();
    gie = 1'b1;
    level = 3'd6; raise(11'd1 << 5); wait_entry(16'h1006, "R7 ext lvl6", 1'b1); clear_all();
    level = 3'd6; raise(11'd1 << 6); expect_none(5, "R7 uart lvl6"); clear_all();
    level = 3'd7; raise(11'd1 << 5); expect_none(5, "R7 ext lvl7"); clear_all();
    level = 3'd7; raise(11'd1 << 3); wait_entry(16'h1000, "R7 dma lvl7", 1'b1); clear_all();
    level = 3'd1; raise(11'd1 << 10); wait_entry(16'h101A, "R7 pio lvl1", 1'b1); clear_all();
    level = 3'd2; raise(11'd1 << 10); expect_none(5, "R7 pio lvl2"); clear_all();
    level = 3'd3; raise(11'd1 << 8); wait_entry(16'h1012, "R7 tim1 lvl3", 1'b1); clear_all();
    level = 3'd0;
  endtask

  task automatic t_order();
    gie = 1'b1; level = 3'd0;
    raise((11'd1 << 8) | (11'd1 << 3));
    wait_entry(16'h1000, "R8 dma first", 1'b0);
    chk(wake == 1'b1, "R10 tim1 waiting", wake, 1);
    done = 1'b1; @(negedge clk); done = 1'b0;
    wait_entry(16'h1012, "R8 tim1 second", 1'b1);
    clear_all();
    raise((11'd1 << 10) | 11'd1);
    wait_entry(16'h101C, "R8 watchdog first", 1'b1);
    wait_entry(16'h101A, "R8 pio second", 1'b1);
    clear_all();
  endtask

  // R9 stall, R3 fall while stalled drops the request
  task automatic t_busy();
    gie = 1'b1; level = 3'd0;
    raise(11'b100);
    wait_entry(16'h101E, "R9 nmi open", 1'b0);
    raise(11'd1 << 5);
    @(negedge clk);
    chk(wake == 1'b1, "R9 ext pending while busy", wake, 1);
    rd_chk(8'h12, 8'h10, "R3 ext bit while busy");
    repeat (3) @(negedge clk);
    chk(req && vec == 16'h101E, "R9 vector held", vec, 16'h101E);
    irq[5] = 1'b0;
    @(negedge clk);
    chk(wake == 1'b0, "R3 fall clears pending", wake, 0);
    rd_chk(8'h12, 8'h00, "R3 fall clears bit busy");
    done = 1'b1; @(negedge clk); done = 1'b0;
    expect_none(5, "R3 dropped ext");
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bus();
    t_nonmask();
    t_masked();
    t_enable();
    t_level();
    t_order();
    t_busy();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule